// File: doc/BRIEF.md
# Receive Queue with Per-Byte Error Status

This block sits behind a serial receiver and holds incoming bytes in a first-in first-out queue of 64 entries. Each entry keeps the byte together with three flags: parity error, framing error and break. Deserialisation and bit timing happen upstream. The upstream logic presents a finished byte with its flags and pulses a write strobe.

Software sees two things: the byte at the head of the queue and an 8-bit line-status vector. The specific error bits in that vector always describe the head entry, which is the next byte to be read. A separate summary bit shows that an errored byte is stored somewhere in the queue.

A line-status interrupt is raised as soon as an errored byte arrives, even when good bytes are still waiting ahead of it. It is raised again when that byte moves up to the head. This lets software clear the first interrupt, drain the good bytes, and then be told exactly which error the head byte carries.

Top module: `rx_err_fifo`

## Requirements
- R1: Accepted bytes leave in arrival order. `rd_data` shows the head byte while the queue is non-empty and reads 0 when it is empty. A read strobe on an empty queue changes nothing.
- R2: Status bit 0 is 1 exactly when at least one byte is stored. Bits 5 and 6 are always 0.
- R3: Status bit 7 is 1 while any stored entry carries parity, framing or break. It returns to 0 once the last such entry has been read out.
- R4: Status bits 2 (parity), 3 (framing) and 4 (break) show the flags of the head entry only. They are 0 while the head byte is clean or the queue is empty.
- R5: A write strobe while 64 bytes are stored is an overrun. The byte is dropped, including its error flags, and status bit 1 is 1 from the next cycle on. This holds even if a read strobe comes in the same cycle.
- R6: A line-status read strobe clears status bit 1, unless a new overrun occurs in that same cycle.
- R7: An accepted errored byte sets the interrupt-pending state in the following cycle, whatever is queued ahead of it.
- R8: When a read removes the head and the entry behind it is errored, pending is set again in the following cycle.
- R9: An overrun sets pending in the following cycle.
- R10: A line-status read strobe clears pending. A set event in the same cycle wins.
- R11: `irq` equals pending gated by `lsr_ie`. Pending is held while the enable is low.
- R12: After reset the queue is empty, the status vector is 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for a received byte |
| wr_data | input | 8 | Received byte |
| wr_par | input | 1 | Parity error flag of the byte |
| wr_frm | input | 1 | Framing error flag of the byte |
| wr_brk | input | 1 | Break flag of the byte |
| rd_en | input | 1 | Pop the head byte |
| rd_data | output | 8 | Head byte (0 when empty) |
| lsr_rd | input | 1 | Line-status read strobe |
| lsr_ie | input | 1 | Line-status interrupt enable |
| lsr | output | 8 | Line-status vector |
| irq | output | 1 | Line-status interrupt |

## Verification
The central scenario is a clean byte followed by a parity-errored byte. The bench checks that only the summary and data-ready bits appear at first. A design that decoded the tail entry instead of the head would show bit 2 too early. A design that raised the interrupt only at the head would stay silent after the second write.

The bench then clears the interrupt, pops the clean byte, and expects a second interrupt along with bit 2. It fills the queue and writes once more, checking that the dropped byte's error flag never reaches the summary bit. It also checks that an overrun alongside a read still drops the byte. Set-versus-clear collisions on the pending state and a masked-then-unmasked interrupt are checked too. These catch designs that let the clear win or that discard events while the interrupt is masked.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rx_ent_t;

  localparam int ENT_W = $bits(rx_ent_t);

  localparam int ST_READY = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_PAR   = 2;
  localparam int ST_FRM   = 3;
  localparam int ST_BRK   = 4;
  localparam int ST_SUM   = 7;

  function automatic logic ent_bad(input rx_ent_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rx_err_store.sv
module rx_err_store
  import rx_err_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  rx_ent_t push_ent,
  input  logic    pop,
  output rx_ent_t head_ent,
  output rx_ent_t second_ent,
  output logic    empty,
  output logic    full,
  output logic    multi
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  rx_ent_t         mem [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [AW-1:0]   rd_ptr_nx;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + AW'(1);
  endfunction

  assign rd_ptr_nx = wrap_inc(rd_ptr_q);

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = wrap_inc(wr_ptr_q);
    if (pop)  rd_ptr_d = rd_ptr_nx;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= push_ent;
  end

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == DEPTH_C);
  assign multi      = (cnt_q > CW'(1));
  assign head_ent   = empty ? '0 : mem[rd_ptr_q];
  assign second_ent = multi ? mem[rd_ptr_nx] : '0;
endmodule

// File: rtl/rx_err_tally.sv
module rx_err_tally #(
  parameter int DEPTH = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic any
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [CW-1:0] bad_q, bad_d;

  always_comb begin
    case ({inc, dec})
      2'b10:   bad_d = bad_q + CW'(1);
      2'b01:   bad_d = bad_q - CW'(1);
      default: bad_d = bad_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= '0;
    else        bad_q <= bad_d;
  end

  assign any = (bad_q != '0);
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       empty,
  input  rx_ent_t    head_ent,
  input  logic       err_any,
  input  logic       ovr_evt,
  input  logic       arr_evt,
  input  logic       head_evt,
  input  logic       lsr_rd,
  input  logic       lsr_ie,
  output logic [7:0] lsr,
  output logic       irq
);
  logic ovr_q, ovr_d;
  logic pend_q, pend_d;
  logic set_any;

  assign set_any = ovr_evt | arr_evt | head_evt;

  always_comb begin
    ovr_d  = ovr_q;
    pend_d = pend_q;
    if (lsr_rd)  ovr_d  = 1'b0;
    if (ovr_evt) ovr_d  = 1'b1;
    if (lsr_rd)  pend_d = 1'b0;
    if (set_any) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      ovr_q  <= ovr_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    lsr           = '0;
    lsr[ST_READY] = !empty;
    lsr[ST_OVR]   = ovr_q;
    lsr[ST_PAR]   = !empty && head_ent.par;
    lsr[ST_FRM]   = !empty && head_ent.frm;
    lsr[ST_BRK]   = !empty && head_ent.brk;
    lsr[ST_SUM]   = err_any;
  end

  assign irq = pend_q & lsr_ie;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rx_err_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_par,
  input  logic              wr_frm,
  input  logic              wr_brk,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lsr_rd,
  input  logic              lsr_ie,
  output logic [7:0]        lsr,
  output logic              irq
);
  rx_ent_t in_ent, head_ent, second_ent;
  logic    empty, full, multi;
  logic    push, pop;
  logic    err_any;
  logic    arr_evt, head_evt, ovr_evt;

  always_comb begin
    in_ent.data = wr_data;
    in_ent.par  = wr_par;
    in_ent.frm  = wr_frm;
    in_ent.brk  = wr_brk;
  end

  assign push     = wr_en && !full;
  assign pop      = rd_en && !empty;
  assign ovr_evt  = wr_en && full;
  assign arr_evt  = push && ent_bad(in_ent);
  assign head_evt = pop && multi && ent_bad(second_ent);

  rx_err_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_ent(in_ent), .pop(pop),
    .head_ent(head_ent), .second_ent(second_ent),
    .empty(empty), .full(full), .multi(multi)
  );

  rx_err_tally #(.DEPTH(DEPTH)) u_tally (
    .clk(clk), .rst_n(rst_n),
    .inc(arr_evt), .dec(pop && ent_bad(head_ent)),
    .any(err_any)
  );

  rx_err_status u_status (
    .clk(clk), .rst_n(rst_n),
    .empty(empty), .head_ent(head_ent), .err_any(err_any),
    .ovr_evt(ovr_evt), .arr_evt(arr_evt), .head_evt(head_evt),
    .lsr_rd(lsr_rd), .lsr_ie(lsr_ie),
    .lsr(lsr), .irq(irq)
  );

  assign rd_data = head_ent.data;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       wr_par,
  input logic       wr_frm,
  input logic       wr_brk,
  input logic       rd_en,
  input logic       lsr_rd,
  input logic       lsr_ie,
  input logic       full,
  input logic [7:0] lsr,
  input logic       irq
);
  // R11
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> lsr_ie);

  // R4
  head_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lsr[4:2]) |-> (lsr[7] && lsr[0]));

  // R2
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6:5] == 2'b00);

  // R5
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> lsr[1]);

  // R7
  arrival_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !full && (wr_par || wr_frm || wr_brk)) |=> (irq || !lsr_ie));

  // R10
  clear_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !wr_en && !rd_en) |=> !irq);

  // R6
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !wr_en) |=> !lsr[1]);
endmodule

bind rx_err_fifo rx_err_fifo_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_par(wr_par),
  .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd),
  .lsr_ie(lsr_ie), .full(full), .lsr(lsr), .irq(irq)
);

// File: tb/rx_err_fifo_tb.sv
module rx_err_fifo_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en, wr_par, wr_frm, wr_brk;
  logic [7:0] wr_data;
  logic       rd_en, lsr_rd, lsr_ie;
  logic [7:0] rd_data, lsr;
  logic       irq;

  int n_run;
  int n_fail;
  bit done;

  rx_err_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_par(wr_par), .wr_frm(wr_frm), .wr_brk(wr_brk), .rd_en(rd_en),
    .rd_data(rd_data), .lsr_rd(lsr_rd), .lsr_ie(lsr_ie), .lsr(lsr), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; rd_en = 0; lsr_rd = 0;
  endtask

  // One operation lasting one clock edge; results sampled at the next falling edge.
  task automatic op(input logic w, input logic [7:0] d, input logic [2:0] f,
                    input logic r, input logic s);
    @(negedge clk);
    wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = f; rd_en = r; lsr_rd = s;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    idle(); wr_data = 0; wr_par = 0; wr_frm = 0; wr_brk = 0; lsr_ie = 1;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 lsr", lsr, 8'h00);
    chk("R12 irq", {7'b0, irq}, 8'h00);
    chk("R1 empty rd_data", rd_data, 8'h00);
  endtask

  task automatic t_deferred();
    do_reset();
    op(1, 8'h55, 3'b000, 0, 0);
    chk("R2 ready", lsr, 8'h01);
    chk("R7 clean no irq", {7'b0, irq}, 8'h00);
    op(1, 8'hAA, 3'b001, 0, 0);
    chk("R3 R4 summary only", lsr, 8'h81);
    chk("R7 arrival irq", {7'b0, irq}, 8'h01);
    op(0, 0, 0, 0, 1);
    chk("R10 cleared", {7'b0, irq}, 8'h00);
    chk("R1 head", rd_data, 8'h55);
    op(0, 0, 0, 1, 0);
    chk("R8 head irq", {7'b0, irq}, 8'h01);
    chk("R4 parity at head", lsr, 8'h85);
    chk("R1 second", rd_data, 8'hAA);
    op(0, 0, 0, 0, 1);
    op(0, 0, 0, 1, 0);
    chk("R3 drained", lsr, 8'h00);
    chk("R8 no irq on clean drain", {7'b0, irq}, 8'h00);
    op(0, 0, 0, 1, 0);
    chk("R1 empty read ignored", lsr, 8'h00);
  endtask

  task automatic t_kinds();
    do_reset();
    op(1, 8'h10, 3'b010, 0, 0);
    chk("R4 framing", lsr, 8'h89);
    op(1, 8'h20, 3'b100, 0, 0);
    op(0, 0, 0, 1, 1);
    chk("R4 break", lsr, 8'h91);
    chk("R8 break head irq", {7'b0, irq}, 8'h01);
    op(0, 0, 0, 1, 1);
    chk("R3 all gone", lsr, 8'h00);
  endtask

  task automatic t_overrun();
    do_reset();
    for (int i = 0; i < 64; i++) op(1, 8'(i), 3'b000, 0, 0);
    chk("R7 no irq when full", {7'b0, irq}, 8'h00);
    op(1, 8'hEE, 3'b001, 0, 0);
    chk("R5 overrun lsr", lsr, 8'h03);
    chk("R9 overrun irq", {7'b0, irq}, 8'h01);
    op(0, 0, 0, 0, 1);
    chk("R6 cleared", lsr, 8'h01);
    op(1, 8'hEF, 3'b000, 1, 0);
    chk("R5 overrun with read", lsr, 8'h03);
    for (int i = 1; i < 64; i++) begin
      @(negedge clk);
      if (rd_data !== 8'(i)) chk("R1 order", rd_data, 8'(i));
      op(0, 0, 0, 1, 0);
    end
    chk("R5 dropped byte absent", lsr, 8'h02);
    op(1, 8'h00, 3'b000, 0, 1);
    chk("R6 read clears", lsr, 8'h01);
    op(0, 0, 0, 1, 0);
  endtask

  task automatic t_collide_mask();
    do_reset();
    lsr_ie = 0;
    op(1, 8'h33, 3'b001, 0, 0);
    chk("R11 masked", {7'b0, irq}, 8'h00);
    @(negedge clk); lsr_ie = 1; #1;
    chk("R11 held", {7'b0, irq}, 8'h01);
    op(1, 8'h44, 3'b010, 0, 1);
    chk("R10 set wins", {7'b0, irq}, 8'h01);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 0;
    t_reset();
    t_deferred();
    t_kinds();
    t_overrun();
    t_collide_mask();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual running expected done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule